// File: doc/BRIEF.md
# Condition-Field Compare Unit

This block compares two operands and writes the outcome into one 4-bit field of a 32-bit condition register. The second operand is either a 64-bit register value or a 16-bit immediate. A width select decides whether the comparison covers the low 32 bits or all 64 bits. A signedness select chooses between a two's-complement compare and an unsigned magnitude compare.

A separate byte-match mode takes the low byte of the first operand and looks for it in all eight bytes of the second operand. The caller supplies the current condition register and the summary-overflow flag. The block returns the whole register with only the chosen field replaced.

The result is registered and appears together with a valid strobe one cycle after the request. Instruction decode and register-file reads belong to the surrounding pipeline.

Top module: `crf_cmp_unit`

## Requirements
- R1: While rst_ni is low, and after it is released until the first request, valid_o is 0 and cr_o is 0.
- R2: valid_o is 1 exactly in the cycle after a cycle with valid_i=1. cr_o changes only on such a cycle and otherwise holds its value, whatever the other inputs do.
- R3: field_i=k selects cr_o bits [31-4k : 28-4k], so field 0 is bits 31..28 and field 7 is bits 3..0. Every other bit of cr_o equals the cr_i that was presented with the request.
- R4: Within the written field, bit 3 is less-than, bit 2 is greater-than and bit 1 is equal. In compare modes exactly one of these three bits is set.
- R5: With bytematch_i=0 and unsigned_i=0, the operands are compared as two's-complement numbers.
- R6: With unsigned_i=1, the operands are compared as unsigned magnitudes.
- R7: With wide_i=0, only bits 31..0 of each operand take part. They are sign-extended for a signed compare and zero-extended for an unsigned one. With wide_i=1, all 64 bits take part.
- R8: With use_imm_i=1, imm_i replaces opb_i as the second operand. It is sign-extended to 64 bits for a signed compare and zero-extended for an unsigned one.
- R9: With bytematch_i=1, bit 2 of the field is set if any of the eight bytes of opb_i equals opa_i[7:0], and bits 3, 1 and 0 are cleared. In this mode unsigned_i, wide_i, use_imm_i, imm_i and so_i have no effect.
- R10: In compare modes, bit 0 of the field is a copy of so_i taken with the request, independent of the comparison result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| bytematch_i | input | 1 | 1 selects the any-byte-equal mode |
| unsigned_i | input | 1 | 1 selects an unsigned compare |
| wide_i | input | 1 | 1 compares 64 bits, 0 compares the low 32 bits |
| use_imm_i | input | 1 | 1 uses imm_i as the second operand |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| field_i | input | 3 | Index of the target field |
| cr_i | input | 32 | Current condition register |
| so_i | input | 1 | Summary-overflow flag |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| cr_o | output | 32 | Updated condition register |

## Verification
The width reduction and the immediate extension both apply in a single compare when wide_i=0 and use_imm_i=1. The bench provokes this with first operands whose upper 32 bits disagree with their lower half, so any leak of the high half changes the outcome. Sign or zero extension of the immediate is also combined with a nonzero so_i. Each case is judged against a behavioural reference that widens both operands with integer arithmetic and patches the expected field into the prior register value.

// File: rtl/crf_cmp_pkg.sv
package crf_cmp_pkg;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_nib_t;
endpackage

// File: rtl/crf_operand_prep.sv
module crf_operand_prep #(
  parameter int DW = 64,
  parameter int HW = 32,
  parameter int IW = 16
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [IW-1:0] imm_i,
  input  logic          use_imm_i,
  input  logic          unsigned_i,
  input  logic          wide_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  logic [DW-1:0] imm_ext, b_src;

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] x, input logic wide, input logic uns);
    if (wide)     return x;
    else if (uns) return {{(DW-HW){1'b0}}, x[HW-1:0]};
    else          return {{(DW-HW){x[HW-1]}}, x[HW-1:0]};
  endfunction

  always_comb begin
    imm_ext = unsigned_i ? {{(DW-IW){1'b0}}, imm_i} : {{(DW-IW){imm_i[IW-1]}}, imm_i};
    b_src   = use_imm_i ? imm_ext : opb_i;
    a_o     = narrow(opa_i, wide_i, unsigned_i);
    b_o     = narrow(b_src, wide_i, unsigned_i);
  end
endmodule

// File: rtl/crf_mag_cmp.sv
module crf_mag_cmp #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          unsigned_i,
  output logic          lt_o,
  output logic          gt_o,
  output logic          eq_o
);
  logic [DW-1:0] bias, a_b, b_b;

  // flipping the sign bit maps two's-complement order onto unsigned order
  assign bias = {~unsigned_i, {(DW-1){1'b0}}};
  assign a_b  = a_i ^ bias;
  assign b_b  = b_i ^ bias;
  assign lt_o = a_b < b_b;
  assign eq_o = a_i == b_i;
  assign gt_o = ~lt_o & ~eq_o;
endmodule

// File: rtl/crf_byte_scan.sv
module crf_byte_scan #(
  parameter int DW = 64,
  parameter int BW = 8
) (
  input  logic [BW-1:0] key_i,
  input  logic [DW-1:0] data_i,
  output logic          hit_o
);
  localparam int NB = DW / BW;
  logic [NB-1:0] hit;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign hit[k] = data_i[k*BW +: BW] == key_i;
  end

  assign hit_o = |hit;
endmodule

// File: rtl/crf_field_merge.sv
module crf_field_merge #(
  parameter int NF = 8,
  parameter int FW = 4,
  localparam int IDX_W = $clog2(NF),
  localparam int CR_W = NF * FW
) (
  input  logic [CR_W-1:0]  cr_i,
  input  logic [IDX_W-1:0] field_i,
  input  logic [FW-1:0]    nib_i,
  output logic [CR_W-1:0]  cr_o
);
  // field 0 sits at the most significant end
  for (genvar f = 0; f < NF; f++) begin : g_field
    assign cr_o[CR_W-1-f*FW -: FW] = (field_i == IDX_W'(f)) ? nib_i : cr_i[CR_W-1-f*FW -: FW];
  end
endmodule

// File: rtl/crf_cmp_unit.sv
module crf_cmp_unit
  import crf_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  parameter int IMM_W  = 16,
  parameter int NFIELD = 8,
  localparam int IDX_W = $clog2(NFIELD),
  localparam int CR_W  = NFIELD * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              bytematch_i,
  input  logic              unsigned_i,
  input  logic              wide_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [IDX_W-1:0]  field_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic              so_i,
  output logic              valid_o,
  output logic [CR_W-1:0]   cr_o
);
  logic [DATA_W-1:0] a_ext, b_ext;
  logic              lt, gt, eq, byte_hit;
  crf_nib_t          nib;
  logic [CR_W-1:0]   cr_next;
  logic              valid_q;
  logic [CR_W-1:0]   cr_q;

  crf_operand_prep #(.DW(DATA_W), .HW(HALF_W), .IW(IMM_W)) u_prep (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .imm_i      (imm_i),
    .use_imm_i  (use_imm_i),
    .unsigned_i (unsigned_i),
    .wide_i     (wide_i),
    .a_o        (a_ext),
    .b_o        (b_ext)
  );

  crf_mag_cmp #(.DW(DATA_W)) u_cmp (
    .a_i        (a_ext),
    .b_i        (b_ext),
    .unsigned_i (unsigned_i),
    .lt_o       (lt),
    .gt_o       (gt),
    .eq_o       (eq)
  );

  crf_byte_scan #(.DW(DATA_W), .BW(8)) u_scan (
    .key_i  (opa_i[7:0]),
    .data_i (opb_i),
    .hit_o  (byte_hit)
  );

  always_comb begin
    if (bytematch_i) nib = '{lt: 1'b0, gt: byte_hit, eq: 1'b0, so: 1'b0};
    else             nib = '{lt: lt, gt: gt, eq: eq, so: so_i};
  end

  crf_field_merge #(.NF(NFIELD), .FW(FIELD_W)) u_merge (
    .cr_i    (cr_i),
    .field_i (field_i),
    .nib_i   (nib),
    .cr_o    (cr_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cr_q    <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) cr_q <= cr_next;
    end
  end

  assign valid_o = valid_q;
  assign cr_o    = cr_q;
endmodule

// File: rtl/crf_cmp_unit_chk.sv
module crf_cmp_unit_chk #(
  parameter int NFIELD = 8,
  parameter int FW = 4,
  localparam int IDX_W = $clog2(NFIELD),
  localparam int CR_W = NFIELD * FW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             bytematch_i,
  input logic [IDX_W-1:0] field_i,
  input logic [CR_W-1:0]  cr_i,
  input logic             so_i,
  input logic             valid_o,
  input logic [CR_W-1:0]  cr_o
);
  logic [IDX_W-1:0] fld_q;
  logic             bm_q, so_q;
  logic [CR_W-1:0]  cr_in_q, keep_mask;
  logic [FW-1:0]    sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q   <= '0;
      bm_q    <= 1'b0;
      so_q    <= 1'b0;
      cr_in_q <= '0;
    end else if (valid_i) begin
      fld_q   <= field_i;
      bm_q    <= bytematch_i;
      so_q    <= so_i;
      cr_in_q <= cr_i;
    end
  end

  always_comb begin
    keep_mask = '1;
    keep_mask[CR_W-1-FW*int'(fld_q) -: FW] = '0;
    sel = cr_o[CR_W-1-FW*int'(fld_q) -: FW];
  end

  a_r2_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> (!valid_o && $stable(cr_o)));
  a_r3_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((cr_o & keep_mask) == (cr_in_q & keep_mask)));
  a_r4_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bm_q) |-> ($countones(sel[3:1]) == 1));
  a_r10_so_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bm_q) |-> (sel[0] == so_q));
  a_r9_match_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bm_q) |-> (sel[3] == 1'b0 && sel[1] == 1'b0 && sel[0] == 1'b0));
endmodule

bind crf_cmp_unit crf_cmp_unit_chk #(.NFIELD(NFIELD), .FW(crf_cmp_pkg::FIELD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .bytematch_i (bytematch_i),
  .field_i     (field_i),
  .cr_i        (cr_i),
  .so_i        (so_i),
  .valid_o     (valid_o),
  .cr_o        (cr_o)
);

// File: tb/crf_cmp_unit_bench.sv
`timescale 1ns/1ps
module crf_cmp_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, bytematch_i = 1'b0, unsigned_i = 1'b0, wide_i = 1'b1, use_imm_i = 1'b0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic [15:0] imm_i = '0;
  logic [2:0]  field_i = '0;
  logic [31:0] cr_i = '0;
  logic        so_i = 1'b0;
  logic        valid_o;
  logic [31:0] cr_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_cr = '0;

  always #5 clk_i = ~clk_i;

  crf_cmp_unit u_crf_cmp_unit (
    .clk_i, .rst_ni, .valid_i, .bytematch_i, .unsigned_i, .wide_i, .use_imm_i,
    .opa_i, .opb_i, .imm_i, .field_i, .cr_i, .so_i, .valid_o, .cr_o
  );

  function automatic logic [31:0] ref_cr();
    logic [63:0] a, b;
    logic [3:0]  nib;
    logic [31:0] r;
    bit hit = 0;
    if (bytematch_i) begin
      for (int k = 0; k < 8; k++) if (opb_i[8*k +: 8] == opa_i[7:0]) hit = 1;
      nib = {1'b0, hit, 2'b00};
    end else begin
      a = opa_i;
      b = use_imm_i ? (unsigned_i ? {48'd0, imm_i} : {{48{imm_i[15]}}, imm_i}) : opb_i;
      if (!wide_i) begin
        a = unsigned_i ? {32'd0, a[31:0]} : {{32{a[31]}}, a[31:0]};
        b = unsigned_i ? {32'd0, b[31:0]} : {{32{b[31]}}, b[31:0]};
      end
      if (unsigned_i) nib = {a < b, a > b, a == b, so_i};
      else nib = {$signed(a) < $signed(b), $signed(a) > $signed(b), a == b, so_i};
    end
    r = cr_i;
    r[31-4*int'(field_i) -: 4] = nib;
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // inputs already set; run one cycle and compare at the next negedge
  task automatic fire(input string tag, input logic v);
    valid_i = v;
    if (v) exp_cr = ref_cr();
    @(negedge clk_i);
    check({tag, " valid R2"}, 64'(valid_o), 64'(v));
    check({tag, " cr"}, 64'(cr_o), 64'(exp_cr));
  endtask

  task automatic setc(input logic bm, input logic uns, input logic wide, input logic ui,
                      input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                      input logic [2:0] f, input logic [31:0] c, input logic so);
    bytematch_i = bm; unsigned_i = uns; wide_i = wide; use_imm_i = ui;
    opa_i = a; opb_i = b; imm_i = im; field_i = f; cr_i = c; so_i = so;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", 64'(valid_o), 64'd0);
    check("R1 cr in reset", 64'(cr_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after reset", 64'(valid_o), 64'd0);
    check("R1 cr after reset", 64'(cr_o), 64'd0);

    // R5 signed wide, both orders
    setc(0,0,1,0, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 0, 2, 32'h35055050, 0);
    fire("R5 neg<pos", 1);
    setc(0,0,1,0, 64'h00000000aaaaaaaa, 64'hffffffffaaaaaaaa, 0, 2, 32'h12345678, 0);
    fire("R5 pos>neg", 1);
    // R6 unsigned wide
    setc(0,1,1,0, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 0, 5, 32'h0, 0);
    fire("R6 unsigned gt", 1);
    // R7 narrow: high halves ignored
    setc(0,0,0,0, 64'hffffffffaaaaaaaa, 64'h00000000aaaaaaaa, 0, 1, 32'hffffffff, 0);
    fire("R7 narrow signed eq", 1);
    setc(0,1,0,0, 64'h000000000001c026, 64'hfedf3fff0001c025, 0, 6, 32'h35055050, 0);
    fire("R7 narrow unsigned gt", 1);
    setc(0,0,0,0, 64'h0000000080000000, 64'h0000000000000001, 0, 3, 32'h0, 0);
    fire("R7 narrow signed sign bit lt", 1);
    // R8 immediate
    setc(0,0,1,1, 64'hfffffffffffffffb, 64'h5, 16'hfffb, 4, 32'h0, 0);
    fire("R8 signed imm eq", 1);
    setc(0,1,1,1, 64'h00000000301fc7a7, 64'h0, 16'd31132, 5, 32'h0, 1);
    fire("R8 unsigned imm gt R10", 1);
    setc(0,1,1,1, 64'h10, 64'hffff, 16'hffff, 0, 32'h0, 0);
    fire("R8 unsigned imm zero-ext lt", 1);
    setc(0,0,0,1, 64'h12345678fffffffe, 64'h0, 16'hfffe, 7, 32'haaaaaaaa, 1);
    fire("R8 narrow signed imm eq R10", 1);
    // R10 SO copy
    setc(0,0,1,0, 64'd7, 64'd7, 0, 0, 32'h0, 1);
    fire("R10 so with eq", 1);
    // R9 byte match
    setc(1,0,1,0, 64'h000000000000000b, 64'h0001030507090b0f, 0, 1, 32'h0, 1);
    fire("R9 hit so ignored", 1);
    setc(1,1,0,1, 64'hffffffffffffff02, 64'h0001030507090b0f, 16'h0002, 1, 32'hffffffff, 1);
    fire("R9 miss", 1);
    setc(1,0,1,0, 64'h77, 64'h7700000000000000, 0, 7, 32'h0, 0);
    fire("R9 top byte hit", 1);
    // R3 field boundaries
    setc(0,0,1,0, 64'd1, 64'd2, 0, 0, 32'h0fffffff, 0);
    fire("R3 field0", 1);
    setc(0,0,1,0, 64'd2, 64'd1, 0, 7, 32'hfffffff0, 0);
    fire("R3 field7", 1);
    // R2 idle cycles with changing inputs
    setc(0,1,0,0, 64'd9, 64'd1, 0, 3, 32'h5a5a5a5a, 1);
    fire("R2 idle hold", 0);
    setc(1,0,1,0, 64'd0, 64'd0, 0, 4, 32'h0, 0);
    fire("R2 idle hold 2", 0);
    // R4 back-to-back random
    for (int i = 0; i < 60; i++) begin
      setc($urandom_range(0,3) == 0, 1'($urandom), 1'($urandom), 1'($urandom),
           {$urandom, $urandom}, (i % 4 == 0) ? {$urandom, $urandom} & 64'hffffffff0000ffff : {$urandom, $urandom},
           16'($urandom), 3'($urandom), $urandom, 1'($urandom));
      if (i % 5 == 0) opb_i = opa_i;
      fire("R4 random", $urandom_range(0,4) != 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule